// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A short shift register keeps the resolved outcomes of the most recent branches. Each new outcome enters at bit 0, and a 1 means taken. In the default mode, the history is XORed with the word-address bits of the fetch PC. The result selects one entry of a table of 2-bit saturating counters. The most significant bit of the selected counter is the prediction. A build parameter can drop the PC from the index, so that the history alone selects the counter.

The fetch stage raises a predict request with the PC. One clock later the block returns the taken/not-taken guess and the table index it used. The fetch stage keeps that index alongside the branch. When the branch resolves, it sends the saved index and the real outcome to the update port. The block then trains that exact counter and shifts the outcome into the history, even though the history may have moved on since the prediction.

Top module: `gshare_predictor`

## Requirements
- R1: Reset is synchronous and active high. After reset the history is all zeros, every counter holds weakly not-taken (2'b01), and pred_vld_o is low. The first prediction after reset is therefore not-taken.
- R2: pred_vld_o is high exactly in the cycle after a cycle with pred_req_i high, and low otherwise. pred_taken_o and pred_idx_o are registered and change only in response to a request.
- R3: With XOR_MODE=1, the returned index equals the history XOR PC bits [5:2], both taken in the request cycle.
- R4: Each accepted update shifts the history left by one bit. The outcome enters bit 0 (1 = taken) and the oldest bit is dropped. Without an update the history holds.
- R5: A taken outcome raises the addressed counter by one, and the counter saturates at 2'b11.
- R6: A not-taken outcome lowers the addressed counter by one, and the counter saturates at 2'b00.
- R7: An update trains the counter at upd_idx_i, whatever index the current history would produce.
- R8: The prediction is bit 1 of the counter, where 00 and 01 mean not-taken and 10 and 11 mean taken. A counter at 2'b11 needs two not-taken updates before it predicts not-taken.
- R9: When a request and an update arrive in the same cycle, the prediction uses the history and the counter values from before that update.
- R10: A single branch whose outcomes repeat taken, taken, taken, not-taken is predicted with no misses after two periods of that pattern.
- R11: With XOR_MODE=0, the returned index equals the history alone, and the PC does not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_req_i | input | 1 | Predict request |
| pred_pc_i | input | PC_W | Fetch PC of the branch |
| pred_vld_o | output | 1 | Prediction result valid |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_idx_o | output | HIST_W | Table index used by the prediction |
| upd_vld_i | input | 1 | Resolved-branch update strobe |
| upd_idx_i | input | HIST_W | Index saved at prediction time |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench builds two copies of the block with the default 4-bit history and 32-bit PC. One copy uses XOR_MODE=1 and the other XOR_MODE=0, and both receive the same inputs. Each copy is compared against its own behavioural model of the history and counters. With only 16 entries, the bench can drive a counter into both saturation limits, including the extra updates applied at each limit. A 4-bit history also lets a period-four pattern converge within a few periods. Because of the small table, the bench can also aim a same-cycle request at exactly the entry being written.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Saturating step of a 2-bit counter toward the resolved outcome.
  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
      end
    end
  endgenerate

  assign hist_o = hist_q;

endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int HIST_W   = 4,
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter bit XOR_MODE = 1'b1
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);

  localparam logic [PC_W-1:0] USED_MASK =
    ((PC_W'(1) << HIST_W) - PC_W'(1)) << PC_LSB;

  logic unused_pc;

  generate
    if (XOR_MODE) begin : g_xor
      assign idx       = hist ^ pc[PC_LSB +: HIST_W];
      assign unused_pc = ^(pc & ~USED_MASK);
    end else begin : g_glob
      assign idx       = hist;
      assign unused_pc = ^pc;
    end
  endgenerate

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic [IDX_W-1:0] wr_idx,
  output ctr_t             wr_old,
  input  logic             wr_en,
  input  ctr_t             wr_data
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];
  ctr_t rd_q;

  // Read-first: a same-cycle write is not seen by the registered read.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_NT;
      rd_q <= CTR_WEAK_NT;
    end else begin
      if (wr_en) tbl[wr_idx] <= wr_data;
      if (rd_en) rd_q <= tbl[rd_idx];
    end
  end

  assign rd_ctr = rd_q;
  assign wr_old = tbl[wr_idx];

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_W   = 4,
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter bit XOR_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_req_i,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_vld_o,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_idx_o,
  input  logic              upd_vld_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_taken_i
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] look_idx;
  logic [HIST_W-1:0] idx_q;
  logic              vld_q;
  ctr_t              rd_ctr;
  ctr_t              upd_old;
  ctr_t              upd_new;

  gshare_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_vld_i),
    .bit_in   (upd_taken_i),
    .hist_o   (hist_q)
  );

  gshare_index #(
    .HIST_W   (HIST_W),
    .PC_W     (PC_W),
    .PC_LSB   (PC_LSB),
    .XOR_MODE (XOR_MODE)
  ) u_index (
    .pc   (pred_pc_i),
    .hist (hist_q),
    .idx  (look_idx)
  );

  assign upd_new = ctr_next(upd_old, upd_taken_i);

  gshare_pht #(.IDX_W(HIST_W)) u_pht (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (pred_req_i),
    .rd_idx  (look_idx),
    .rd_ctr  (rd_ctr),
    .wr_idx  (upd_idx_i),
    .wr_old  (upd_old),
    .wr_en   (upd_vld_i),
    .wr_data (upd_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= pred_req_i;
      if (pred_req_i) idx_q <= look_idx;
    end
  end

  assign pred_vld_o   = vld_q;
  assign pred_idx_o   = idx_q;
  assign pred_taken_o = ctr_dir(rd_ctr);

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk
  import gshare_pkg::*;
#(
  parameter int HIST_W   = 4,
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter bit XOR_MODE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_req_i,
  input logic [PC_W-1:0]   pred_pc_i,
  input logic              pred_vld_o,
  input logic [HIST_W-1:0] pred_idx_o,
  input logic              upd_vld_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] hist,
  input ctr_t              upd_old,
  input ctr_t              upd_new
);

  logic unused_chk;
  assign unused_chk = ^pred_pc_i;

  // R2
  a_r2_vld_after_req: assert property (@(posedge clk) disable iff (rst)
    pred_req_i |=> pred_vld_o);
  a_r2_no_vld_without_req: assert property (@(posedge clk) disable iff (rst)
    !pred_req_i |=> !pred_vld_o);

  generate
    if (XOR_MODE) begin : g_xor_chk
      // R3
      a_r3_xor_index: assert property (@(posedge clk) disable iff (rst)
        pred_req_i |=> (pred_idx_o ==
          ($past(hist) ^ $past(pred_pc_i[PC_LSB +: HIST_W]))));
    end else begin : g_glob_chk
      // R11
      a_r11_hist_index: assert property (@(posedge clk) disable iff (rst)
        pred_req_i |=> (pred_idx_o == $past(hist)));
    end
    if (HIST_W > 1) begin : g_shift_chk
      // R4
      a_r4_hist_shift: assert property (@(posedge clk) disable iff (rst)
        upd_vld_i |=> (hist == {$past(hist[HIST_W-2:0]), $past(upd_taken_i)}));
    end
  endgenerate

  // R4
  a_r4_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_vld_i |=> $stable(hist));

  // R5
  a_r5_sat_up: assert property (@(posedge clk) disable iff (rst)
    (upd_vld_i && upd_taken_i) |->
      (upd_new == ((upd_old == 2'b11) ? 2'b11 : upd_old + 2'd1)));

  // R6
  a_r6_sat_down: assert property (@(posedge clk) disable iff (rst)
    (upd_vld_i && !upd_taken_i) |->
      (upd_new == ((upd_old == 2'b00) ? 2'b00 : upd_old - 2'd1)));

endmodule

bind gshare_predictor gshare_predictor_chk #(
  .HIST_W   (HIST_W),
  .PC_W     (PC_W),
  .PC_LSB   (PC_LSB),
  .XOR_MODE (XOR_MODE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pred_req_i  (pred_req_i),
  .pred_pc_i   (pred_pc_i),
  .pred_vld_o  (pred_vld_o),
  .pred_idx_o  (pred_idx_o),
  .upd_vld_i   (upd_vld_i),
  .upd_taken_i (upd_taken_i),
  .hist        (hist_q),
  .upd_old     (upd_old),
  .upd_new     (upd_new)
);

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb;

  localparam int HW = 4;
  localparam int PW = 32;
  localparam int NV = 16;

  // Vector: {pc[7:0], outcome}; one branch repeating T,T,T,N.
  localparam logic [8:0] VEC [NV] = '{
    {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b0},
    {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b0},
    {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b0},
    {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b1}, {8'h34,1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_req = 1'b0;
  logic [PW-1:0] pred_pc = '0;
  logic upd_vld = 1'b0;
  logic [HW-1:0] upd_idx = '0;
  logic upd_taken = 1'b0;

  logic x_vld, x_taken, g_vld, g_taken;
  logic [HW-1:0] x_idx, g_idx;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] m_x [16];
  logic [1:0] m_g [16];
  logic [HW-1:0] m_h;

  always #5 clk = ~clk;

  gshare_predictor #(.HIST_W(HW), .PC_W(PW), .PC_LSB(2), .XOR_MODE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .pred_req_i(pred_req), .pred_pc_i(pred_pc),
    .pred_vld_o(x_vld), .pred_taken_o(x_taken), .pred_idx_o(x_idx),
    .upd_vld_i(upd_vld), .upd_idx_i(upd_idx), .upd_taken_i(upd_taken)
  );

  gshare_predictor #(.HIST_W(HW), .PC_W(PW), .PC_LSB(2), .XOR_MODE(1'b0)) u_dut_glb (
    .clk(clk), .rst(rst), .pred_req_i(pred_req), .pred_pc_i(pred_pc),
    .pred_vld_o(g_vld), .pred_taken_o(g_taken), .pred_idx_o(g_idx),
    .upd_vld_i(upd_vld), .upd_idx_i(upd_idx), .upd_taken_i(upd_taken)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_x[i] = 2'b01;
      m_g[i] = 2'b01;
    end
    m_h = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pred_req = 1'b0; upd_vld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // One cycle of stimulus; expectations taken from the model before update.
  task automatic do_cycle(input bit preq, input logic [PW-1:0] pc, input bit uv,
                          input logic [HW-1:0] ui, input bit ut, input string tag);
    logic [HW-1:0] ex_idx;
    logic ex_t, eg_t;
    @(negedge clk);
    pred_req = preq; pred_pc = pc; upd_vld = uv; upd_idx = ui; upd_taken = ut;
    ex_idx = m_h ^ pc[5:2];
    ex_t   = m_x[ex_idx][1];
    eg_t   = m_g[m_h][1];
    @(posedge clk);
    #2;
    check(x_vld == preq, {"R2 valid ", tag}, int'(x_vld), int'(preq));
    if (preq) begin
      check(x_idx == ex_idx, {"R3 xor index ", tag}, int'(x_idx), int'(ex_idx));
      check(x_taken == ex_t, {"R8 xor prediction ", tag}, int'(x_taken), int'(ex_t));
      check(g_idx == m_h, {"R11 global index ", tag}, int'(g_idx), int'(m_h));
      check(g_taken == eg_t, {"R11 global prediction ", tag}, int'(g_taken), int'(eg_t));
    end
    pred_req = 1'b0; upd_vld = 1'b0;
    if (uv) begin
      m_x[ui] = step(m_x[ui], ut);
      m_g[ui] = step(m_g[ui], ut);
      m_h = {m_h[HW-2:0], ut};
    end
  endtask

  function automatic logic [PW-1:0] pc_for(input logic [HW-1:0] want);
    return PW'({(m_h ^ want), 2'b00});
  endfunction

  initial begin
    int misses;
    logic [HW-1:0] got;
    model_reset();
    do_reset();

    // R1: reset state
    #2;
    check(x_vld == 1'b0, "R1 valid low after reset", int'(x_vld), 0);
    do_cycle(1'b1, 32'h34, 1'b0, '0, 1'b0, "R1 first");
    check(x_taken == 1'b0, "R1 first prediction not-taken", int'(x_taken), 0);
    check(x_idx == 4'hD, "R1 index with zero history", int'(x_idx), 13);
    do_cycle(1'b0, 32'h0, 1'b0, '0, 1'b0, "R2 idle");

    // Vector walk: period-four pattern (R10), R4 and R7 via model
    do_reset();
    misses = 0;
    for (int v = 0; v < NV; v++) begin
      do_cycle(1'b1, {24'h0, VEC[v][8:1]}, 1'b0, '0, 1'b0, "walk");
      got = x_idx;
      if (v >= 8 && x_taken != VEC[v][0]) misses++;
      do_cycle(1'b0, 32'h0, 1'b1, got, VEC[v][0], "walk update");
    end
    check(misses == 0, "R10 no misses after warm-up", misses, 0);
    check(m_h == 4'b1110, "R4 history after walk", int'(m_h), 14);

    // R5 / R8: saturate up at entry 5, then walk down
    do_reset();
    for (int k = 0; k < 4; k++) do_cycle(1'b0, 32'h0, 1'b1, 4'd5, 1'b1, "R5 up");
    do_cycle(1'b1, pc_for(4'd5), 1'b0, '0, 1'b0, "R5 saturated");
    check(x_taken == 1'b1, "R5 taken at top", int'(x_taken), 1);
    do_cycle(1'b0, 32'h0, 1'b1, 4'd5, 1'b0, "R8 one miss");
    do_cycle(1'b1, pc_for(4'd5), 1'b0, '0, 1'b0, "R8 after one");
    check(x_taken == 1'b1, "R8 still taken after one not-taken", int'(x_taken), 1);
    do_cycle(1'b0, 32'h0, 1'b1, 4'd5, 1'b0, "R8 two miss");
    do_cycle(1'b1, pc_for(4'd5), 1'b0, '0, 1'b0, "R8 after two");
    check(x_taken == 1'b0, "R8 not-taken after two", int'(x_taken), 0);

    // R6: saturate down, then one taken must stay not-taken
    for (int k = 0; k < 4; k++) do_cycle(1'b0, 32'h0, 1'b1, 4'd5, 1'b0, "R6 down");
    do_cycle(1'b0, 32'h0, 1'b1, 4'd5, 1'b1, "R6 one up");
    do_cycle(1'b1, pc_for(4'd5), 1'b0, '0, 1'b0, "R6 floor");
    check(x_taken == 1'b0, "R6 floor holds at zero", int'(x_taken), 0);

    // R7: train index 9 while history points elsewhere; index 9 shifts to taken
    do_cycle(1'b0, 32'h0, 1'b1, 4'd9, 1'b1, "R7 train");
    do_cycle(1'b1, pc_for(4'd9), 1'b0, '0, 1'b0, "R7 read");
    check(x_taken == 1'b1, "R7 supplied index trained", int'(x_taken), 1);

    // R9: same-cycle predict and update of entry 5 (counter 01 -> 10)
    do_cycle(1'b1, pc_for(4'd5), 1'b1, 4'd5, 1'b1, "R9 collide");
    check(x_taken == 1'b0, "R9 prediction sees old counter", int'(x_taken), 0);
    do_cycle(1'b1, pc_for(4'd5), 1'b0, '0, 1'b0, "R9 after");
    check(x_taken == 1'b1, "R9 next prediction sees new counter", int'(x_taken), 1);

    // R11: global copy ignores PC
    do_cycle(1'b1, 32'hFFFF_FFFC, 1'b0, '0, 1'b0, "R11 pc high");
    check(g_idx == m_h, "R11 index independent of pc", int'(g_idx), int'(m_h));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule